// File: doc/BRIEF.md
# Sector Write-Back Overflow Guard

This block sits between a sector-organised write buffer and the memory-side write path of a compressed main memory. When the write buffer evicts a sector, it hands over the new compressed byte count of every block it holds, a mask of which blocks it holds, and a mask of which blocks a prefetch buffer currently holds. The guard asks the address translator for the sector's present layout. Blocks are packed back to back from the sector base, so each block's offset is the sum of the footprints in front of it. The guard then decides whether the new data fits where the old data sits.

If no block in front of the last one grows, the sector is written in place. Each slot keeps its allotment, so no neighbour moves. If some non-last block grows, writing it would spill over the blocks behind it. The guard therefore re-lays the sector from the first growing block onward. It fetches, in ascending order, only those displaced blocks that neither on-chip buffer can supply. That is the read half of a read-modify-write. Only then does it issue the compacted write. After the write is acknowledged, it sends the size codes of the whole sector to the translator in a single one-cycle update.

One eviction is in flight at a time. The state machine has six states:
- IDLE accepts work; ev_valid moves it to CHECK.
- CHECK queries the translator. at_ack moves it to FETCH when reads are needed, otherwise to WRITE.
- FETCH issues a read. rd_ack moves it to WAIT_FILL.
- WAIT_FILL waits for the data. rd_fill moves it back to FETCH while reads remain, otherwise to WRITE.
- WRITE issues the write. wr_ack moves it to UPDATE.
- UPDATE commits the metadata and returns to IDLE unconditionally.

Top module: `sect_ovf_guard`

## Requirements
- R1: ev_ready is 1 only in IDLE. After an eviction is accepted, ev_ready stays 0 through the metadata-update cycle and returns to 1 in the cycle after it.
- R2: In the cycle after acceptance, at_req rises with at_sector equal to the evicted sector. It stays high until at_ack, and at_size is sampled in the at_ack cycle.
- R3: A byte count of BLK (64) or more means the block is stored raw, and its footprint is BLK. Any smaller count is its own footprint. Size fields are SZW bits wide, and block i sits at bits [i*SZW +: SZW].
- R4: With no overflow, no read is issued and wr_rmw is 0. Each non-last block commits its old footprint. The last block commits its new footprint if it is held in the write buffer, and its old footprint otherwise.
- R5: Overflow means a block held in the write buffer, other than the last one, whose new footprint is larger than its old footprint. Let f be the lowest such index. Blocks below f commit their old footprint. Blocks at f or above commit their new footprint if held in the write buffer, and their old footprint otherwise. wr_rmw is 1.
- R6: On overflow, a read is issued for each block above f that is in neither the write buffer nor the prefetch buffer, in ascending index order. rd_req and rd_blk hold until rd_ack, and the next read waits for rd_fill.
- R7: wr_req rises only after every required fill has returned. wr_req, wr_sizes and wr_rmw hold until wr_ack.
- R8: The cycle after wr_ack carries a one-cycle md_upd pulse, with md_sector and all committed footprints on md_sizes.
- R9: The size field of a block not held in the write buffer has no effect on the committed sizes or on the overflow decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Eviction offered by the write buffer |
| ev_ready | output | 1 | Guard can accept an eviction (backpressure) |
| ev_sector | input | SECW | Sector address of the eviction |
| ev_dirty | input | NBLK | Blocks held in the write buffer |
| ev_pb_hit | input | NBLK | Blocks held in the prefetch buffer |
| ev_size | input | NBLK*SZW | New compressed byte counts |
| at_req | output | 1 | Layout query to the address translator |
| at_sector | output | SECW | Sector being queried |
| at_ack | input | 1 | Translator answer valid |
| at_size | input | NBLK*SZW | Current footprints in memory |
| rd_req | output | 1 | Read of a displaced block |
| rd_sector | output | SECW | Sector of the read |
| rd_blk | output | IDXW | Block index of the read |
| rd_ack | input | 1 | Read request accepted |
| rd_fill | input | 1 | Read data has arrived on chip |
| wr_req | output | 1 | Compacted sector write |
| wr_sector | output | SECW | Sector of the write |
| wr_sizes | output | NBLK*SZW | Footprints laid out by the write |
| wr_rmw | output | 1 | Write follows an overflow re-layout |
| wr_ack | input | 1 | Write accepted |
| md_upd | output | 1 | Metadata update pulse to the translator |
| md_sector | output | SECW | Sector of the update |
| md_sizes | output | NBLK*SZW | Committed footprints of all blocks |

## Verification
The bench builds the guard with four blocks per sector, 7-bit size fields and 64-byte blocks. With four blocks, a grower can sit at index 0 or at an interior index. The same setting exercises a growing last block, which is not an overflow. Fetch lists can mix blocks held in the prefetch buffer, blocks held in the write buffer, and blocks held nowhere. The 7-bit field admits counts above 64, so both the raw cap on the new size and an old footprint that is already raw are reached. Oversized values in clean slots show that those fields are ignored.

// File: rtl/sog_pkg.sv
package sog_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_WAIT_FILL,
        S_WRITE,
        S_UPDATE
    } sog_state_e;

endpackage

// File: rtl/sog_layout.sv
// Combinational comparison of new and old sector layouts.
module sog_layout #(
    parameter int NBLK = 4,
    parameter int SZW  = 7,
    parameter int BLK  = 64
) (
    input  logic [NBLK-1:0]     dirty,
    input  logic [NBLK-1:0]     pb_hit,
    input  logic [NBLK*SZW-1:0] new_sz,
    input  logic [NBLK*SZW-1:0] old_sz,
    output logic                overflow,
    output logic [NBLK-1:0]     fetch_mask,
    output logic [NBLK*SZW-1:0] commit_sz
);
    localparam logic [SZW-1:0] BLK_W = SZW'(BLK);

    logic [NBLK-1:0] grow;
    logic [NBLK-1:0] after_f;    // strictly above first grower
    logic [NBLK-1:0] from_f;     // at or above first grower
    logic [SZW-1:0]  nfp [NBLK];
    logic [SZW-1:0]  ofp [NBLK];

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        // R3: raw cap on footprint
        assign nfp[i] = (new_sz[i*SZW +: SZW] >= BLK_W) ? BLK_W : new_sz[i*SZW +: SZW];
        assign ofp[i] = (old_sz[i*SZW +: SZW] >= BLK_W) ? BLK_W : old_sz[i*SZW +: SZW];
        if (i < NBLK-1) begin : g_mid
            assign grow[i] = dirty[i] && (nfp[i] > ofp[i]);
        end else begin : g_last
            assign grow[i] = 1'b0;
        end
    end

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int j = 0; j < NBLK; j++) begin
            after_f[j] = seen;
            seen       = seen | grow[j];
            from_f[j]  = seen;
        end
    end

    always_comb begin
        for (int j = 0; j < NBLK; j++) begin
            fetch_mask[j] = after_f[j] && !dirty[j] && !pb_hit[j];
            if (dirty[j] && (from_f[j] || j == NBLK-1))
                commit_sz[j*SZW +: SZW] = nfp[j];
            else
                commit_sz[j*SZW +: SZW] = ofp[j];
        end
    end

    assign overflow = |grow;

endmodule

// File: rtl/sog_pick.sv
// Lowest set bit index of a request vector.
module sog_pick #(
    parameter int N    = 4,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int k = N-1; k >= 0; k--) begin
            if (req[k]) idx = IDXW'(k);
        end
    end
endmodule

// File: rtl/sect_ovf_guard.sv
module sect_ovf_guard
    import sog_pkg::*;
#(
    parameter int NBLK = 4,
    parameter int SZW  = 7,
    parameter int BLK  = 64,
    parameter int SECW = 16,
    localparam int IDXW = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int VW   = NBLK*SZW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_valid,
    output logic            ev_ready,
    input  logic [SECW-1:0] ev_sector,
    input  logic [NBLK-1:0] ev_dirty,
    input  logic [NBLK-1:0] ev_pb_hit,
    input  logic [VW-1:0]   ev_size,
    output logic            at_req,
    output logic [SECW-1:0] at_sector,
    input  logic            at_ack,
    input  logic [VW-1:0]   at_size,
    output logic            rd_req,
    output logic [SECW-1:0] rd_sector,
    output logic [IDXW-1:0] rd_blk,
    input  logic            rd_ack,
    input  logic            rd_fill,
    output logic            wr_req,
    output logic [SECW-1:0] wr_sector,
    output logic [VW-1:0]   wr_sizes,
    output logic            wr_rmw,
    input  logic            wr_ack,
    output logic            md_upd,
    output logic [SECW-1:0] md_sector,
    output logic [VW-1:0]   md_sizes
);
    sog_state_e state_q, state_d;

    logic [SECW-1:0] sector_q;
    logic [NBLK-1:0] dirty_q, pb_q, pend_q;
    logic [VW-1:0]   new_q, commit_q;
    logic            rmw_q;

    logic            ovf;
    logic [NBLK-1:0] fetch;
    logic [VW-1:0]   commit;
    logic [IDXW-1:0] cur;
    logic [NBLK-1:0] pend_rest;

    sog_layout #(.NBLK(NBLK), .SZW(SZW), .BLK(BLK)) i_layout (
        .dirty      (dirty_q),
        .pb_hit     (pb_q),
        .new_sz     (new_q),
        .old_sz     (at_size),
        .overflow   (ovf),
        .fetch_mask (fetch),
        .commit_sz  (commit)
    );

    sog_pick #(.N(NBLK), .IDXW(IDXW)) i_pick (
        .req (pend_q),
        .idx (cur)
    );

    always_comb begin
        pend_rest      = pend_q;
        pend_rest[cur] = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (ev_valid) state_d = S_CHECK;
            S_CHECK:     if (at_ack)   state_d = (|fetch) ? S_FETCH : S_WRITE;
            S_FETCH:     if (rd_ack)   state_d = S_WAIT_FILL;
            S_WAIT_FILL: if (rd_fill)  state_d = (|pend_rest) ? S_FETCH : S_WRITE;
            S_WRITE:     if (wr_ack)   state_d = S_UPDATE;
            S_UPDATE:                  state_d = S_IDLE;
            default:                   state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sector_q <= '0;
            dirty_q  <= '0;
            pb_q     <= '0;
            new_q    <= '0;
            commit_q <= '0;
            pend_q   <= '0;
            rmw_q    <= 1'b0;
        end else begin
            if (state_q == S_IDLE && ev_valid) begin
                sector_q <= ev_sector;
                dirty_q  <= ev_dirty;
                pb_q     <= ev_pb_hit;
                new_q    <= ev_size;
            end
            if (state_q == S_CHECK && at_ack) begin
                commit_q <= commit;
                pend_q   <= fetch;
                rmw_q    <= ovf;
            end
            if (state_q == S_WAIT_FILL && rd_fill) begin
                pend_q <= pend_rest;
            end
        end
    end

    // Outputs
    always_comb begin
        ev_ready  = (state_q == S_IDLE);
        at_req    = (state_q == S_CHECK);
        rd_req    = (state_q == S_FETCH);
        wr_req    = (state_q == S_WRITE);
        md_upd    = (state_q == S_UPDATE);
        at_sector = sector_q;
        rd_sector = sector_q;
        rd_blk    = cur;
        wr_sector = sector_q;
        wr_sizes  = commit_q;
        wr_rmw    = rmw_q;
        md_sector = sector_q;
        md_sizes  = commit_q;
    end

    // Assertions
    p_busy_backpressure_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_ready);

    p_query_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (at_req && !at_ack) |=> at_req && $stable(at_sector));

    p_fetch_offchip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (!dirty_q[rd_blk] && !pb_q[rd_blk]));

    p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req && $stable(rd_blk));

    p_no_early_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (pend_q == '0));

    p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req && $stable(wr_sizes) && $stable(wr_rmw));

    p_update_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> md_upd ##1 (!md_upd && ev_ready));

endmodule

// File: tb/test_sect_ovf_guard.sv
module test_sect_ovf_guard;
    localparam int NBLK = 4;
    localparam int SZW  = 7;
    localparam int BLK  = 64;
    localparam int SECW = 16;
    localparam int VW   = NBLK*SZW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ev_valid = 1'b0;
    logic            ev_ready;
    logic [SECW-1:0] ev_sector = '0;
    logic [NBLK-1:0] ev_dirty = '0;
    logic [NBLK-1:0] ev_pb_hit = '0;
    logic [VW-1:0]   ev_size = '0;
    logic            at_req;
    logic [SECW-1:0] at_sector;
    logic            at_ack = 1'b0;
    logic [VW-1:0]   at_size = '0;
    logic            rd_req;
    logic [SECW-1:0] rd_sector;
    logic [1:0]      rd_blk;
    logic            rd_ack = 1'b0;
    logic            rd_fill = 1'b0;
    logic            wr_req;
    logic [SECW-1:0] wr_sector;
    logic [VW-1:0]   wr_sizes;
    logic            wr_rmw;
    logic            wr_ack = 1'b0;
    logic            md_upd;
    logic [SECW-1:0] md_sector;
    logic [VW-1:0]   md_sizes;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    sect_ovf_guard #(.NBLK(NBLK), .SZW(SZW), .BLK(BLK), .SECW(SECW)) i_sect_ovf_guard (
        .clk, .rst_n, .ev_valid, .ev_ready, .ev_sector, .ev_dirty, .ev_pb_hit, .ev_size,
        .at_req, .at_sector, .at_ack, .at_size,
        .rd_req, .rd_sector, .rd_blk, .rd_ack, .rd_fill,
        .wr_req, .wr_sector, .wr_sizes, .wr_rmw, .wr_ack,
        .md_upd, .md_sector, .md_sizes
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] pk(input int a0, input int a1, input int a2, input int a3);
        return {SZW'(a3), SZW'(a2), SZW'(a1), SZW'(a0)};
    endfunction

    task automatic run_evict(input string name, input logic [SECW-1:0] sec,
                             input logic [NBLK-1:0] dirty, input logic [NBLK-1:0] pb,
                             input logic [VW-1:0] newsz, input logic [VW-1:0] oldsz,
                             input logic [NBLK-1:0] exp_fetch, input logic [VW-1:0] exp_commit,
                             input logic exp_rmw);
        @(negedge clk);
        check({name, " R1 ready in idle"}, 64'(ev_ready), 64'd1);
        ev_sector = sec; ev_dirty = dirty; ev_pb_hit = pb; ev_size = newsz; ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        check({name, " R1 busy"}, 64'(ev_ready), 64'd0);
        check({name, " R2 query"}, 64'(at_req), 64'd1);
        check({name, " R2 sector"}, 64'(at_sector), 64'(sec));
        @(negedge clk);
        check({name, " R2 query held"}, 64'(at_req), 64'd1);
        at_size = oldsz; at_ack = 1'b1;
        @(negedge clk);
        at_ack = 1'b0; at_size = '1;
        for (int j = 0; j < NBLK; j++) begin
            if (exp_fetch[j]) begin
                check({name, " R6 read req"}, 64'(rd_req), 64'd1);
                check({name, " R6 read blk"}, 64'(rd_blk), 64'(j));
                check({name, " R6 read sector"}, 64'(rd_sector), 64'(sec));
                check({name, " R7 no write during fetch"}, 64'(wr_req), 64'd0);
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
                check({name, " R6 wait fill"}, 64'(rd_req), 64'd0);
                @(negedge clk);
                check({name, " R6 still waiting"}, 64'({rd_req, wr_req}), 64'd0);
                rd_fill = 1'b1;
                @(negedge clk);
                rd_fill = 1'b0;
            end
        end
        check({name, " R6 no extra read"}, 64'(rd_req), 64'd0);
        check({name, " R7 write req"}, 64'(wr_req), 64'd1);
        check({name, " R4/R5 write sizes"}, 64'(wr_sizes), 64'(exp_commit));
        check({name, " R4/R5 rmw flag"}, 64'(wr_rmw), 64'(exp_rmw));
        check({name, " R7 write sector"}, 64'(wr_sector), 64'(sec));
        @(negedge clk);
        check({name, " R7 write held"}, 64'({wr_req, wr_sizes}), 64'({1'b1, exp_commit}));
        check({name, " R8 no early update"}, 64'(md_upd), 64'd0);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        check({name, " R8 update pulse"}, 64'(md_upd), 64'd1);
        check({name, " R8 update sizes"}, 64'(md_sizes), 64'(exp_commit));
        check({name, " R8 update sector"}, 64'(md_sector), 64'(sec));
        check({name, " R1 busy in update"}, 64'(ev_ready), 64'd0);
        @(negedge clk);
        check({name, " R8 pulse ends"}, 64'(md_upd), 64'd0);
        check({name, " R1 ready again"}, 64'(ev_ready), 64'd1);
    endtask

    task automatic t_reset;
        check("R1 reset ready", 64'(ev_ready), 64'd1);
        check("R2 reset no query", 64'(at_req), 64'd0);
        check("R6 reset no read", 64'(rd_req), 64'd0);
        check("R7 reset no write", 64'(wr_req), 64'd0);
        check("R8 reset no update", 64'(md_upd), 64'd0);
    endtask

    // R4: interior shrink keeps allotment
    task automatic t_shrink_in_place;
        run_evict("R4 shrink", 16'h0101, 4'b0011, 4'b0000,
                  pk(15, 30, 0, 0), pk(20, 30, 10, 40), 4'b0000, pk(20, 30, 10, 40), 1'b0);
    endtask

    // R4: last block grows without overflow
    task automatic t_last_grow;
        run_evict("R4 last grow", 16'h0202, 4'b1000, 4'b0000,
                  pk(0, 0, 0, 63), pk(10, 10, 10, 10), 4'b0000, pk(10, 10, 10, 63), 1'b0);
    endtask

    // R5/R6: block 0 grows, block 2 in prefetch buffer -> fetch 1 and 3
    task automatic t_ovf_first;
        run_evict("R5 ovf blk0", 16'h0303, 4'b0001, 4'b0100,
                  pk(25, 0, 0, 0), pk(10, 10, 10, 10), 4'b1010, pk(25, 10, 10, 10), 1'b1);
    endtask

    // R3/R5/R6: interior block goes raw, fetch 2 and 3
    task automatic t_ovf_raw;
        run_evict("R3 raw ovf", 16'h0404, 4'b0010, 4'b0000,
                  pk(0, 100, 0, 0), pk(20, 20, 20, 20), 4'b1100, pk(20, 64, 20, 20), 1'b1);
    endtask

    // R5: all blocks on chip, first grower at 1, no reads
    task automatic t_ovf_all_dirty;
        run_evict("R5 ovf all dirty", 16'h0505, 4'b1111, 4'b0000,
                  pk(5, 40, 8, 9), pk(10, 30, 10, 10), 4'b0000, pk(10, 40, 8, 9), 1'b1);
    endtask

    // R9: clean slots carry huge sizes that must not matter
    task automatic t_clean_ignored;
        run_evict("R9 clean ignored", 16'h0606, 4'b0100, 4'b0000,
                  pk(127, 127, 5, 127), pk(10, 10, 10, 10), 4'b0000, pk(10, 10, 10, 10), 1'b0);
    endtask

    // R3: old raw block stays raw, no growth
    task automatic t_raw_stays;
        run_evict("R3 raw stays", 16'h0707, 4'b0001, 4'b0000,
                  pk(100, 0, 0, 0), pk(64, 12, 12, 12), 4'b0000, pk(64, 12, 12, 12), 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_shrink_in_place();
        t_last_grow();
        t_ovf_first();
        t_ovf_raw();
        t_ovf_all_dirty();
        t_clean_ignored();
        t_raw_stays();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule